// File: doc/BRIEF.md
# FIFO Trigger-Level Interrupt Generator

This block decides when a UART requests service for its transmit FIFO and when it signals that receive data is available. Each direction has its own 2-bit trigger selection field. The field maps onto one of four programmable character thresholds, which default to 1, 4, 8 and 14. Both fields are loaded together by a configuration write strobe and are cleared by reset.

The transmit interrupt is a level that reports a transmit FIFO occupancy below its threshold. The receive interrupt is started by an event: it rises when a character pushed into the receive FIFO brings the occupancy exactly to the threshold. It then stays up while the occupancy is at or above the threshold, and drops once reads bring the occupancy below it. The receive FIFO itself keeps filling past the threshold, so the interrupt must survive further pushes up to a full FIFO.

When the FIFOs are switched off, both thresholds collapse to a single character. The programmed fields are kept and take effect again when the FIFOs are switched back on. The decoded thresholds are driven out so that neighbouring logic can use them.

Top module: `fifo_trig_irq`

## Requirements
- R1: With `fifo_en`=1, `tx_thresh` decodes the stored transmit field as 2'b00→1, 2'b01→4, 2'b10→8, 2'b11→14.
- R2: With `fifo_en`=1, `rx_thresh` decodes the stored receive field with the same mapping: 2'b00→1, 2'b01→4, 2'b10→8, 2'b11→14.
- R3: On a rising clock edge with `cfg_we`=1, the stored fields take the values of `cfg_tx_sel` and `cfg_rx_sel`. With `cfg_we`=0 they hold. Reset clears both fields to 2'b00, so both thresholds become 1.
- R4: With `fifo_en`=0, both thresholds read 1 whatever the stored fields hold. Setting `fifo_en` back to 1 restores the decode of the retained fields on the same cycle.
- R5: After each rising edge, `tx_irq` equals (`tx_count` < threshold), with `tx_count` and the threshold both sampled at that edge.
- R6: `rx_irq` becomes 1 after an edge where `rx_push`=1 and `rx_count`+1 equals the receive threshold. A count that equals the threshold without a push does not set it.
- R7: Once set, `rx_irq` stays 1 while `rx_count` is at or above the threshold. This includes further pushes, and a push at a full count of 16.
- R8: `rx_irq` becomes 0 after an edge where `rx_count` is below the threshold and the R6 condition does not hold.
- R9: While reset is asserted, `tx_irq` and `rx_irq` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fifo_en | input | 1 | FIFOs enabled; when 0 both thresholds are 1 |
| cfg_we | input | 1 | Load strobe for both trigger fields |
| cfg_tx_sel | input | 2 | New transmit trigger field |
| cfg_rx_sel | input | 2 | New receive trigger field |
| tx_count | input | 5 | Transmit FIFO occupancy, 0..16 |
| rx_count | input | 5 | Receive FIFO occupancy before this cycle's push, 0..16 |
| rx_push | input | 1 | A character enters the receive FIFO this cycle |
| tx_irq | output | 1 | Transmit occupancy below threshold |
| rx_irq | output | 1 | Receive trigger level reached |
| tx_thresh | output | 5 | Decoded transmit threshold |
| rx_thresh | output | 5 | Decoded receive threshold |

## Verification
The assertions check several rules on every cycle. Each edge of both interrupts must be justified by the counts and thresholds of the previous cycle. A receive interrupt above threshold must be held. The thresholds must stay inside the legal set, must collapse to 1 while disabled, and the stored fields may change only on a write. Some behaviour can only be shown by the bench scenarios. These cover the exact value each field code decodes to and the retention of the fields across a disable. They also cover the rule that an equal count without a push leaves the receive interrupt low, and a run of pushes up to a full FIFO while the interrupt stays set.

// File: rtl/fifo_trig_pkg.sv
package fifo_trig_pkg;
  localparam int SEL_W = 2;
  localparam int N_CH  = 2;

  typedef logic [SEL_W-1:0] trig_sel_t;

  typedef struct packed {
    trig_sel_t tx;
    trig_sel_t rx;
  } trig_cfg_t;

  localparam int CH_TX = 0;
  localparam int CH_RX = 1;
endpackage

// File: rtl/fifo_trig_cfg.sv
module fifo_trig_cfg
  import fifo_trig_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      we,
  input  trig_cfg_t wdata,
  output trig_cfg_t cfg
);
  trig_cfg_t cfg_q;
  trig_cfg_t cfg_d;

  always_comb begin
    cfg_d = cfg_q;
    if (we) begin
      cfg_d = wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q <= '0;
    end else begin
      cfg_q <= cfg_d;
    end
  end

  assign cfg = cfg_q;

  AST_CFG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !we |=> $stable(cfg_q)); // R3
  AST_CFG_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    we |=> (cfg_q == $past(wdata))); // R3
endmodule

// File: rtl/fifo_trig_decode.sv
module fifo_trig_decode
  import fifo_trig_pkg::*;
#(
  parameter int CNT_W    = 5,
  parameter int LVL_SEL0 = 1,
  parameter int LVL_SEL1 = 4,
  parameter int LVL_SEL2 = 8,
  parameter int LVL_SEL3 = 14,
  parameter int LVL_OFF  = 1
) (
  input  trig_sel_t        sel,
  input  logic             en,
  output logic [CNT_W-1:0] thr
);
  always_comb begin
    thr = CNT_W'(LVL_OFF);
    if (en) begin
      unique case (sel)
        2'b00:   thr = CNT_W'(LVL_SEL0);
        2'b01:   thr = CNT_W'(LVL_SEL1);
        2'b10:   thr = CNT_W'(LVL_SEL2);
        default: thr = CNT_W'(LVL_SEL3);
      endcase
    end
  end
endmodule

// File: rtl/fifo_trig_tx_irq.sv
module fifo_trig_tx_irq #(
  parameter int CNT_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] count,
  input  logic [CNT_W-1:0] thr,
  output logic             irq
);
  logic below;
  logic irq_q;
  logic irq_d;

  always_comb begin
    below = (count < thr);
    irq_d = below;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq_q <= 1'b0;
    end else begin
      irq_q <= irq_d;
    end
  end

  assign irq = irq_q;

  AST_TX_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_q) |-> ($past(count) < $past(thr))); // R5
  AST_TX_FALL: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(irq_q) |-> ($past(count) >= $past(thr))); // R5
endmodule

// File: rtl/fifo_trig_rx_irq.sv
module fifo_trig_rx_irq #(
  parameter int CNT_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push,
  input  logic [CNT_W-1:0] count,
  input  logic [CNT_W-1:0] thr,
  output logic             irq
);
  localparam logic [CNT_W:0] ONE = (CNT_W+1)'(1);

  logic [CNT_W:0] count_nxt;
  logic           hit;
  logic           below;
  logic           irq_q;
  logic           irq_d;

  always_comb begin
    count_nxt = {1'b0, count} + ONE;
    hit       = push && (count_nxt == {1'b0, thr});
    below     = (count < thr);
    irq_d     = irq_q;
    if (hit) begin
      irq_d = 1'b1;
    end else if (below) begin
      irq_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq_q <= 1'b0;
    end else begin
      irq_q <= irq_d;
    end
  end

  assign irq = irq_q;

  AST_RX_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_q) |-> ($past(push) &&
      (({1'b0, $past(count)} + ONE) == {1'b0, $past(thr)}))); // R6
  AST_RX_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_q && (count >= thr)) |=> irq_q); // R7
  AST_RX_FALL: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(irq_q) |-> ($past(count) < $past(thr))); // R8
endmodule

// File: rtl/fifo_trig_irq.sv
module fifo_trig_irq
  import fifo_trig_pkg::*;
#(
  parameter int FIFO_DEPTH = 16,
  parameter int LVL_SEL0   = 1,
  parameter int LVL_SEL1   = 4,
  parameter int LVL_SEL2   = 8,
  parameter int LVL_SEL3   = 14,
  parameter int LVL_OFF    = 1,
  localparam int CNT_W     = $clog2(FIFO_DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             fifo_en,
  input  logic             cfg_we,
  input  logic [1:0]       cfg_tx_sel,
  input  logic [1:0]       cfg_rx_sel,
  input  logic [CNT_W-1:0] tx_count,
  input  logic [CNT_W-1:0] rx_count,
  input  logic             rx_push,
  output logic             tx_irq,
  output logic             rx_irq,
  output logic [CNT_W-1:0] tx_thresh,
  output logic [CNT_W-1:0] rx_thresh
);
  trig_cfg_t        wr_cfg;
  trig_cfg_t        cur_cfg;
  trig_sel_t        sel_arr [N_CH];
  logic [CNT_W-1:0] thr_arr [N_CH];

  always_comb begin
    wr_cfg.tx = cfg_tx_sel;
    wr_cfg.rx = cfg_rx_sel;
    sel_arr[CH_TX] = cur_cfg.tx;
    sel_arr[CH_RX] = cur_cfg.rx;
  end

  fifo_trig_cfg u_cfg (
    .clk   (clk),
    .rst_n (rst_n),
    .we    (cfg_we),
    .wdata (wr_cfg),
    .cfg   (cur_cfg)
  );

  for (genvar g = 0; g < N_CH; g++) begin : g_dec
    fifo_trig_decode #(
      .CNT_W    (CNT_W),
      .LVL_SEL0 (LVL_SEL0),
      .LVL_SEL1 (LVL_SEL1),
      .LVL_SEL2 (LVL_SEL2),
      .LVL_SEL3 (LVL_SEL3),
      .LVL_OFF  (LVL_OFF)
    ) u_dec (
      .sel (sel_arr[g]),
      .en  (fifo_en),
      .thr (thr_arr[g])
    );
  end

  assign tx_thresh = thr_arr[CH_TX];
  assign rx_thresh = thr_arr[CH_RX];

  fifo_trig_tx_irq #(.CNT_W(CNT_W)) u_tx (
    .clk   (clk),
    .rst_n (rst_n),
    .count (tx_count),
    .thr   (tx_thresh),
    .irq   (tx_irq)
  );

  fifo_trig_rx_irq #(.CNT_W(CNT_W)) u_rx (
    .clk   (clk),
    .rst_n (rst_n),
    .push  (rx_push),
    .count (rx_count),
    .thr   (rx_thresh),
    .irq   (rx_irq)
  );

  AST_THR_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    !fifo_en |-> ((tx_thresh == CNT_W'(LVL_OFF)) &&
                  (rx_thresh == CNT_W'(LVL_OFF)))); // R4
  AST_THR_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_en |-> ((tx_thresh == CNT_W'(LVL_SEL0)) || (tx_thresh == CNT_W'(LVL_SEL1)) ||
                 (tx_thresh == CNT_W'(LVL_SEL2)) || (tx_thresh == CNT_W'(LVL_SEL3)))); // R1
  AST_RX_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_en |-> ((rx_thresh == CNT_W'(LVL_SEL0)) || (rx_thresh == CNT_W'(LVL_SEL1)) ||
                 (rx_thresh == CNT_W'(LVL_SEL2)) || (rx_thresh == CNT_W'(LVL_SEL3)))); // R2
endmodule

// File: tb/fifo_trig_irq_tb.sv
module fifo_trig_irq_tb;
  logic       clk;
  logic       rst_n;
  logic       fifo_en;
  logic       cfg_we;
  logic [1:0] cfg_tx_sel;
  logic [1:0] cfg_rx_sel;
  logic [4:0] tx_count;
  logic [4:0] rx_count;
  logic       rx_push;
  logic       tx_irq;
  logic       rx_irq;
  logic [4:0] tx_thresh;
  logic [4:0] rx_thresh;

  typedef struct {
    bit    tx_irq;
    bit    rx_irq;
    int    tx_thr;
    int    rx_thr;
    string tag;
  } exp_t;

  exp_t exp_q[$];
  int   n_checks;
  int   n_fail;
  bit   m_rxirq;
  bit [1:0] m_tx;
  bit [1:0] m_rx;

  fifo_trig_irq u_dut (
    .clk        (clk),
    .rst_n      (rst_n),
    .fifo_en    (fifo_en),
    .cfg_we     (cfg_we),
    .cfg_tx_sel (cfg_tx_sel),
    .cfg_rx_sel (cfg_rx_sel),
    .tx_count   (tx_count),
    .rx_count   (rx_count),
    .rx_push    (rx_push),
    .tx_irq     (tx_irq),
    .rx_irq     (rx_irq),
    .tx_thresh  (tx_thresh),
    .rx_thresh  (rx_thresh)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  function automatic int dec(bit [1:0] s, bit en);
    if (!en) return 1;
    case (s)
      2'b00:   return 1;
      2'b01:   return 4;
      2'b10:   return 8;
      default: return 14;
    endcase
  endfunction

  task automatic check(string tag, string what, int act, int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  endtask

  // Driver: applies one cycle of stimulus and queues the outcome due after the next edge
  task automatic step(bit en, bit we, bit [1:0] ts, bit [1:0] rs,
                      int txc, int rxc, bit push, string tag);
    exp_t e;
    int   ot;
    int   orr;
    @(negedge clk);
    fifo_en    = en;
    cfg_we     = we;
    cfg_tx_sel = ts;
    cfg_rx_sel = rs;
    tx_count   = 5'(txc);
    rx_count   = 5'(rxc);
    rx_push    = push;
    ot  = dec(m_tx, en);
    orr = dec(m_rx, en);
    e.tx_irq = (txc < ot);
    if (push && (rxc + 1 == orr)) m_rxirq = 1'b1;
    else if (rxc < orr)           m_rxirq = 1'b0;
    if (we) begin
      m_tx = ts;
      m_rx = rs;
    end
    e.rx_irq = m_rxirq;
    e.tx_thr = dec(m_tx, en);
    e.rx_thr = dec(m_rx, en);
    e.tag    = tag;
    exp_q.push_back(e);
  endtask

  // Monitor: compares queued outcomes in the middle of the high phase
  always @(posedge clk) begin
    #5;
    if (exp_q.size() > 0) begin
      exp_t e;
      e = exp_q.pop_front();
      check(e.tag, "tx_irq", int'(tx_irq), int'(e.tx_irq));
      check(e.tag, "rx_irq", int'(rx_irq), int'(e.rx_irq));
      check(e.tag, "tx_thresh", int'(tx_thresh), e.tx_thr);
      check(e.tag, "rx_thresh", int'(rx_thresh), e.rx_thr);
    end
  end

  initial begin
    #(20 * 5000);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    n_checks = 0;
    n_fail   = 0;
    m_rxirq  = 1'b0;
    m_tx     = 2'b00;
    m_rx     = 2'b00;
    rst_n      = 1'b0;
    fifo_en    = 1'b1;
    cfg_we     = 1'b0;
    cfg_tx_sel = 2'b11;
    cfg_rx_sel = 2'b11;
    tx_count   = 5'd0;
    rx_count   = 5'd0;
    rx_push    = 1'b0;
    repeat (3) @(negedge clk);
    check("R9", "tx_irq in reset", int'(tx_irq), 0);
    check("R9", "rx_irq in reset", int'(rx_irq), 0);
    check("R3", "tx_thresh reset", int'(tx_thresh), 1);
    check("R3", "rx_thresh reset", int'(rx_thresh), 1);
    rst_n = 1'b1;

    step(1, 0, 2'b11, 2'b11, 0, 0, 0, "R5");
    step(1, 0, 2'b00, 2'b00, 1, 0, 0, "R5");
    step(1, 1, 2'b01, 2'b01, 1, 0, 0, "R1");
    step(1, 0, 2'b10, 2'b10, 3, 0, 0, "R3");
    step(1, 0, 2'b00, 2'b00, 4, 0, 0, "R5");
    step(1, 0, 2'b00, 2'b00, 16, 4, 0, "R6");
    step(1, 0, 2'b00, 2'b00, 16, 2, 1, "R6");
    step(1, 0, 2'b00, 2'b00, 16, 3, 1, "R6");
    for (int c = 4; c <= 16; c++) begin
      step(1, 0, 2'b00, 2'b00, 16, c, 1, "R7");
    end
    step(1, 0, 2'b00, 2'b00, 16, 5, 0, "R7");
    step(1, 0, 2'b00, 2'b00, 16, 4, 0, "R7");
    step(1, 0, 2'b00, 2'b00, 16, 3, 0, "R8");
    step(1, 1, 2'b10, 2'b11, 5, 3, 0, "R2");
    step(1, 0, 2'b00, 2'b00, 7, 12, 0, "R1");
    step(1, 0, 2'b00, 2'b00, 8, 13, 1, "R6");
    step(1, 1, 2'b11, 2'b10, 8, 13, 0, "R1");
    step(1, 0, 2'b00, 2'b00, 13, 7, 0, "R8");
    step(0, 0, 2'b00, 2'b00, 0, 0, 1, "R4");
    step(0, 0, 2'b00, 2'b00, 1, 1, 0, "R4");
    step(1, 0, 2'b00, 2'b00, 1, 1, 0, "R4");
    step(1, 1, 2'b00, 2'b00, 13, 0, 0, "R2");
    step(1, 0, 2'b00, 2'b00, 0, 0, 1, "R6");
    step(1, 0, 2'b00, 2'b00, 0, 0, 0, "R8");
    step(1, 0, 2'b00, 2'b00, 0, 0, 0, "R5");
    repeat (3) @(negedge clk);
    summary();
  end
endmodule